// File: doc/BRIEF.md
# Universal Bus Transceiver Register Core

This block is the digital data path and control of a 16-bit bidirectional bus transceiver, split into two 8-bit halves. Each half carries data in two directions, from side A to side B and from side B to side A, and each direction of each half has its own storage register. A per-direction store enable picks among three ways of moving data: it can follow its input (pass-through), freeze the last value it took when the store enable drops (hold-on-release), or take a new value when a shared bus clock rises while the store enable is low (bus-clocked).

The shared bus clock `bus_ck` is an ordinary input sampled on the system clock `clk`, and its rising edge is detected there. Rather than inout pins, each side has separate input, output and drive-enable buses. Each drive-enable bit marks whether the matching output bit would be driven or left floating. Each direction of each half has its own active-low output enable. A master active-low enable and a power-valid input sit above all of these. All outputs are registered, so each reacts one `clk` cycle after the edge that samples its inputs.

Top module: `ubt_core`

## Requirements
- R1: While `rst` is high at a `clk` edge, every bit of `a_out`, `b_out`, `a_drive_en` and `b_drive_en` is 0 after that edge.
- R2: For half h, the slice of `b_out` for that half (bits 8h+7..8h) equals the same slice of `a_in` sampled at a `clk` edge where `st_ab[h]` is 1, from that edge onward.
- R3: At the first `clk` edge where `st_ab[h]` is 0 after an edge where it was 1, and no bus clock rise is seen at that edge, the slice of `b_out` keeps the value it took at the last edge where `st_ab[h]` was 1, whatever the level of `bus_ck`.
- R4: A bus clock rise is an edge where `bus_ck` is 1 and was 0 at the previous edge. At such an edge, if `st_ab[h]` is 0, the slice of `b_out` for half h takes the sampled `a_in` slice.
- R5: At an edge where `st_ab[h]` is 0 and no bus clock rise is seen, the slice of `b_out` for half h does not change.
- R6: The B-to-A path of each half follows R2 to R5 with `st_ba[h]` in place of `st_ab[h]`, `b_in` as the source and `a_out` as the destination.
- R7: The two halves are independent: inputs of one half, and its store and output enables, never change the outputs of the other half.
- R8: After an edge where `pwr_ok` is 1 and `oen_all` is 0, all 8 bits of the `b_drive_en` slice of half h equal the inverse of `oen_ab[h]`, and all 8 bits of the `a_drive_en` slice equal the inverse of `oen_ba[h]`.
- R9: After an edge where `oen_all` is 1, all 32 drive-enable bits are 0, whatever the per-half enables.
- R10: After an edge where `pwr_ok` is 0, all 32 drive-enable bits are 0, whatever `oen_all` and the per-half enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_ck | input | 1 | Shared bus clock, sampled on `clk` |
| pwr_ok | input | 1 | Supply valid; 0 forces all drive enables off |
| oen_all | input | 1 | Master output enable, active low |
| st_ab | input | 2 | Per-half A-to-B store enable (1 = pass-through) |
| st_ba | input | 2 | Per-half B-to-A store enable (1 = pass-through) |
| oen_ab | input | 2 | Per-half A-to-B output enable, active low |
| oen_ba | input | 2 | Per-half B-to-A output enable, active low |
| a_in | input | 16 | Data arriving on side A |
| b_in | input | 16 | Data arriving on side B |
| a_out | output | 16 | Stored B-to-A data presented on side A |
| b_out | output | 16 | Stored A-to-B data presented on side B |
| a_drive_en | output | 16 | Per-bit drive enable for side A |
| b_drive_en | output | 16 | Per-bit drive enable for side B |

## Verification
The assertions take for granted that every control and data input is stable around the rising `clk` edge. Edges of `bus_ck` and of the store enables count only as seen at those edge samples, so a pulse that begins and ends between two edges is assumed never to occur. The stimulus meets this by changing every input only on the falling `clk` edge and holding each value for at least one full cycle. The bus clock is toggled at random on cycle boundaries, so rises can fall on the same edge as a store-enable release, on edges where the store enable is high, and in long low stretches.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  // Store behaviour chosen for one direction of one half at a clk edge.
  typedef enum logic [1:0] {
    STORE_KEEP  = 2'd0,
    STORE_PASS  = 2'd1,
    STORE_CLOCK = 2'd2
  } store_mode_e;

  function automatic store_mode_e pick_mode(input logic st, input logic ck_rise);
    if (st)           return STORE_PASS;
    else if (ck_rise) return STORE_CLOCK;
    else              return STORE_KEEP;
  endfunction
endpackage

// File: rtl/ubt_bus_clock_sense.sv
module ubt_bus_clock_sense (
  input  logic clk,
  input  logic rst,
  input  logic bus_ck,
  output logic ck_rise
);
  logic ck_last;

  always_ff @(posedge clk) begin
    if (rst) ck_last <= 1'b0;
    else     ck_last <= bus_ck;
  end

  assign ck_rise = bus_ck & ~ck_last;
endmodule

// File: rtl/ubt_path_store.sv
module ubt_path_store
  import ubt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st,
  input  logic             ck_rise,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  store_mode_e mode;

  always_comb mode = pick_mode(st, ck_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (mode)
        STORE_PASS:  q <= din;
        STORE_CLOCK: q <= din;
        default:     q <= q;
      endcase
    end
  end

  // R2 (R6 for the B-to-A instances): pass-through follows the input.
  assert_pass_R2: assert property (@(posedge clk) disable iff (rst)
    st |=> q == $past(din));

  // R4 (R6 for the B-to-A instances): a bus clock rise with store low captures.
  assert_clock_R4: assert property (@(posedge clk) disable iff (rst)
    (!st && ck_rise) |=> q == $past(din));

  // R3 and R5: with store low and no bus clock rise the value is kept.
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!st && !ck_rise) |=> $stable(q));
endmodule

// File: rtl/ubt_half_enables.sv
module ubt_half_enables (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic oen_all,
  input  logic oen_ab,
  input  logic oen_ba,
  output logic ab_drive,
  output logic ba_drive
);
  logic master_on;

  assign master_on = pwr_ok & ~oen_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_drive <= 1'b0;
      ba_drive <= 1'b0;
    end else begin
      ab_drive <= master_on & ~oen_ab;
      ba_drive <= master_on & ~oen_ba;
    end
  end

  assert_enable_on_R8: assert property (@(posedge clk) disable iff (rst)
    (pwr_ok && !oen_all) |=> (ab_drive == !$past(oen_ab)) && (ba_drive == !$past(oen_ba)));

  assert_master_off_R9: assert property (@(posedge clk) disable iff (rst)
    oen_all |=> !ab_drive && !ba_drive);

  assert_power_off_R10: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> !ab_drive && !ba_drive);
endmodule

// File: rtl/ubt_core.sv
module ubt_core #(
  parameter int HALVES = 2,
  parameter int HALF_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_ck,
  input  logic                       pwr_ok,
  input  logic                       oen_all,
  input  logic [HALVES-1:0]          st_ab,
  input  logic [HALVES-1:0]          st_ba,
  input  logic [HALVES-1:0]          oen_ab,
  input  logic [HALVES-1:0]          oen_ba,
  input  logic [HALVES*HALF_W-1:0]   a_in,
  input  logic [HALVES*HALF_W-1:0]   b_in,
  output logic [HALVES*HALF_W-1:0]   a_out,
  output logic [HALVES*HALF_W-1:0]   b_out,
  output logic [HALVES*HALF_W-1:0]   a_drive_en,
  output logic [HALVES*HALF_W-1:0]   b_drive_en
);
  localparam int BUS_W = HALVES * HALF_W;

  logic              ck_rise;
  logic [HALVES-1:0] ab_drive;
  logic [HALVES-1:0] ba_drive;

  ubt_bus_clock_sense u_ck (
    .clk     (clk),
    .rst     (rst),
    .bus_ck  (bus_ck),
    .ck_rise (ck_rise)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    ubt_path_store #(.WIDTH(HALF_W)) u_ab (
      .clk     (clk),
      .rst     (rst),
      .st      (st_ab[h]),
      .ck_rise (ck_rise),
      .din     (a_in[h*HALF_W +: HALF_W]),
      .q       (b_out[h*HALF_W +: HALF_W])
    );

    ubt_path_store #(.WIDTH(HALF_W)) u_ba (
      .clk     (clk),
      .rst     (rst),
      .st      (st_ba[h]),
      .ck_rise (ck_rise),
      .din     (b_in[h*HALF_W +: HALF_W]),
      .q       (a_out[h*HALF_W +: HALF_W])
    );

    ubt_half_enables u_en (
      .clk      (clk),
      .rst      (rst),
      .pwr_ok   (pwr_ok),
      .oen_all  (oen_all),
      .oen_ab   (oen_ab[h]),
      .oen_ba   (oen_ba[h]),
      .ab_drive (ab_drive[h]),
      .ba_drive (ba_drive[h])
    );

    assign b_drive_en[h*HALF_W +: HALF_W] = {HALF_W{ab_drive[h]}};
    assign a_drive_en[h*HALF_W +: HALF_W] = {HALF_W{ba_drive[h]}};
  end

  // R7: a half whose store enables are low and sees no bus clock rise keeps
  // its outputs, whatever the other half does.
  for (genvar h = 0; h < HALVES; h++) begin : g_iso
    assert_isolated_R7: assert property (@(posedge clk) disable iff (rst)
      (!st_ab[h] && !ck_rise) |=> $stable(b_out[h*HALF_W +: HALF_W]));
  end

  // R1: reset clears every output.
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (a_out == '0) && (b_out == '0) && (a_drive_en == '0) && (b_drive_en == '0));

  logic unused_width_ok;
  assign unused_width_ok = (BUS_W == $bits(a_in));
endmodule

// File: tb/ubt_core_test.sv
`timescale 1ns/1ps
module ubt_core_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_ck, pwr_ok, oen_all;
  logic [1:0]  st_ab, st_ba, oen_ab, oen_ba;
  logic [15:0] a_in, b_in;
  logic [15:0] a_out, b_out, a_drive_en, b_drive_en;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #10 clk = ~clk;

  ubt_core uut (
    .clk(clk), .rst(rst), .bus_ck(bus_ck), .pwr_ok(pwr_ok), .oen_all(oen_all),
    .st_ab(st_ab), .st_ba(st_ba), .oen_ab(oen_ab), .oen_ba(oen_ba),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
    .a_drive_en(a_drive_en), .b_drive_en(b_drive_en)
  );

  // Behavioural reference
  logic [7:0] m_b [2];
  logic [7:0] m_a [2];
  logic [7:0] m_eb [2];
  logic [7:0] m_ea [2];
  string      t_b [2];
  string      t_a [2];
  string      t_e;
  bit         m_ck;
  bit         m_st_ab_prev [2];
  bit         m_st_ba_prev [2];

  function automatic string mode_tag(bit st, bit prev_st, bit rise, bit ba);
    if (ba)            return "R6";
    if (st)            return "R2";
    if (rise)          return "R4";
    if (prev_st)       return "R3";
    return "R5";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int h = 0; h < 2; h++) begin
        m_b[h] = 8'h00; m_a[h] = 8'h00; m_eb[h] = 8'h00; m_ea[h] = 8'h00;
        t_b[h] = "R1"; t_a[h] = "R1";
        m_st_ab_prev[h] = 0; m_st_ba_prev[h] = 0;
      end
      t_e  = "R1";
      m_ck = 0;
    end else begin
      bit rise;
      rise = bus_ck && !m_ck;
      for (int h = 0; h < 2; h++) begin
        t_b[h] = mode_tag(st_ab[h], m_st_ab_prev[h], rise, 0);
        t_a[h] = mode_tag(st_ba[h], m_st_ba_prev[h], rise, 1);
        if (st_ab[h] || rise) m_b[h] = a_in[h*8 +: 8];
        if (st_ba[h] || rise) m_a[h] = b_in[h*8 +: 8];
        m_st_ab_prev[h] = st_ab[h];
        m_st_ba_prev[h] = st_ba[h];
        m_eb[h] = (pwr_ok && !oen_all && !oen_ab[h]) ? 8'hFF : 8'h00;
        m_ea[h] = (pwr_ok && !oen_all && !oen_ba[h]) ? 8'hFF : 8'h00;
      end
      t_e  = !pwr_ok ? "R10" : (oen_all ? "R9" : "R8");
      m_ck = bus_ck;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int h = 0; h < 2; h++) begin
      chk(t_b[h], "b_out half", b_out[h*8 +: 8], m_b[h]);
      chk(t_a[h], "a_out half", a_out[h*8 +: 8], m_a[h]);
      chk(t_e, "b_drive_en half", b_drive_en[h*8 +: 8], m_eb[h]);
      chk(t_e, "a_drive_en half", a_drive_en[h*8 +: 8], m_ea[h]);
    end
  endtask

  // One cycle: compare what the last edge produced, then drive new inputs.
  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    rst = 1; bus_ck = 0; pwr_ok = 0; oen_all = 1;
    st_ab = 0; st_ba = 0; oen_ab = 2'b11; oen_ba = 2'b11;
    a_in = 16'h0000; b_in = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset state with busy inputs
    a_in = 16'hA5C3; b_in = 16'h3C5A; st_ab = 2'b11; st_ba = 2'b11;
    pwr_ok = 1; oen_all = 0; oen_ab = 0; oen_ba = 0;
    @(negedge clk);
    chk("R1", "b_out", b_out, 0);
    chk("R1", "a_out", a_out, 0);
    chk("R1", "drive enables", {a_drive_en, b_drive_en}, 0);
    rst = 0;

    // Directed: pass-through on both halves
    step(); a_in = 16'h1234; b_in = 16'h9876;
    step(); st_ab = 2'b00; st_ba = 2'b00; bus_ck = 1;        // release with rise -> clocked
    a_in = 16'hFFFF;
    step(); a_in = 16'h0F0F; bus_ck = 1;                      // no new rise -> hold
    step(); bus_ck = 0; st_ab = 2'b11; a_in = 16'h4321;
    step(); st_ab = 2'b00; a_in = 16'hDEAD; bus_ck = 1;       // held bus_ck high before? no: rise
    step(); st_ab = 2'b11; bus_ck = 0; a_in = 16'h5555;
    step(); st_ab = 2'b00; bus_ck = 1; a_in = 16'h7777;       // latched release with ck high, rise
    step(); bus_ck = 1; a_in = 16'h8888;
    step(); st_ab = 2'b11; bus_ck = 1; a_in = 16'h1111;
    step(); st_ab = 2'b00; bus_ck = 1; a_in = 16'h2222;       // release, ck stays high -> R3

    // R7: half 0 passes, half 1 holds with no bus clock rise
    step(); st_ab = 2'b01; bus_ck = 1; a_in = 16'hABCD;
    step(); a_in = 16'h00EE;
    step();
    chk("R7", "half1 b_out held", b_out[15:8], m_b[1]);
    chk("R7", "half0 b_out follows", b_out[7:0], 8'hEE);
    // Enable priorities
    oen_all = 1; oen_ab = 0; oen_ba = 0;
    step(); oen_all = 0; pwr_ok = 0;
    step(); pwr_ok = 1; oen_ab = 2'b10; oen_ba = 2'b01;
    step(); step();

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      st_ab   = ($urandom_range(0, 2) == 0) ? 2'($urandom) : st_ab;
      st_ba   = ($urandom_range(0, 2) == 0) ? 2'($urandom) : st_ba;
      bus_ck  = ($urandom_range(0, 1) == 0) ? ~bus_ck : bus_ck;
      oen_all = ($urandom_range(0, 9) == 0);
      pwr_ok  = ($urandom_range(0, 19) != 0);
      oen_ab  = 2'($urandom);
      oen_ba  = 2'($urandom);
      a_in    = 16'($urandom);
      b_in    = 16'($urandom);
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule